// File: doc/BRIEF.md
# Floating-Point Register Producer Table

This block pairs a floating-point register file with a per-register producer field, for use in the issue stage of a dynamically scheduled core that renames registers to reservation-station tags. Each producer field holds the tag of the station that will deliver the register's next value. The reserved tag value zero means that no instruction in flight targets the register.

When an instruction issues, the block resolves each of its two source operands. A source comes back either as the current register value or as the tag of the station to wait on. The block also records the issuing station's tag as the new producer of the destination register. The block listens to the result broadcast bus. It writes a register only when the broadcast comes from that register's latest recorded producer. A result whose destination was renamed again later is therefore dropped for that register.

A combinational debug port shows the stored value and producer of any register. Station management, memory buffers and arbitration of the broadcast bus sit outside this block.

Top module: `fp_rename_status`

## Requirements
- R1: Reset is synchronous and active low. After reset every producer field is zero and register i holds INIT_VAL + i.
- R2: If a source index names a register whose producer is zero, the issue outputs for that source give the register value and tag zero.
- R3: If a source index names a register whose producer is nonzero and no matching broadcast occurs in the same cycle, the issue outputs give that producer tag and a value of zero.
- R4: An issue with iss_valid and iss_dst_en high sets the destination's producer to iss_tag at the next edge, even when an older producer is still pending. With iss_dst_en low, no producer field changes because of the issue.
- R5: A broadcast (bus_valid high) whose nonzero bus_tag equals a register's producer writes bus_data into that register and clears its producer at the next edge.
- R6: A broadcast whose tag differs from a register's producer leaves that register's value and producer unchanged. This covers a result whose register has been renamed again.
- R7: If a source register's producer equals the tag on the bus in the same cycle, the source outputs give bus_data and tag zero.
- R8: If a register is renamed and is the target of a matching broadcast in the same cycle, the register takes bus_data and its producer becomes the new issue tag.
- R9: A broadcast with bus_tag zero writes no register and clears no producer.
- R10: Sources are resolved against the mapping held before the same-cycle destination rename, so an instruction that reads and writes one register waits on the older producer.
- R11: dbg_val and dbg_tag give the stored value and producer of register dbg_idx, without bus bypass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| iss_valid | input | 1 | An instruction issues this cycle |
| iss_dst_en | input | 1 | The issuing instruction writes a destination register |
| iss_src_a_idx | input | IDX_W | First source register index |
| iss_src_b_idx | input | IDX_W | Second source register index |
| iss_dst_idx | input | IDX_W | Destination register index |
| iss_tag | input | TAG_W | Nonzero tag of the station receiving the instruction |
| src_a_val | output | DATA_W | First source value (zero when a tag is given) |
| src_a_tag | output | TAG_W | First source producer tag, zero when the value is valid |
| src_b_val | output | DATA_W | Second source value (zero when a tag is given) |
| src_b_tag | output | TAG_W | Second source producer tag, zero when the value is valid |
| bus_valid | input | 1 | A result is broadcast this cycle |
| bus_tag | input | TAG_W | Tag of the station broadcasting |
| bus_data | input | DATA_W | Broadcast result |
| dbg_idx | input | IDX_W | Register selected for the debug read |
| dbg_val | output | DATA_W | Stored value of the selected register |
| dbg_tag | output | TAG_W | Producer field of the selected register |

## Verification
The bench uses the default shape of 16 registers, 4-bit tags and 64-bit data, with a nonzero INIT_VAL. Every register therefore starts with its own distinct value, so a write to the wrong register or a missed reset shows up directly. Four-bit tags give fifteen live stations. In the random phase, tags repeat and stale broadcasts are frequent, which exercises renaming while an older producer is pending and the dropping of late results. Directed cycles place issue and broadcast on the same register in one cycle, which reaches the bypass and rename-over-clear corners.

// File: rtl/frs_pkg.sv
// Package: shared definitions for the producer table.
// Assumes: tag value zero is reserved to mean "no producer".
package frs_pkg;

    // How a source operand was resolved at issue
    typedef enum logic [1:0] {
        SRC_FROM_FILE   = 2'd0,
        SRC_FROM_BUS    = 2'd1,
        SRC_WAIT_TAG    = 2'd2
    } src_kind_e;

    // Returns true when a tag names a real station
    function automatic logic tag_live(input logic [15:0] t);
        return t != '0;
    endfunction

endpackage

// File: rtl/frs_tag_table.sv
// Module: frs_tag_table
// Holds one producer tag per register. Issue renames one register per
// cycle. A broadcast whose tag matches a register's producer clears it.
// Assumes: a rename of a register has priority over the clear of that register.
module frs_tag_table #(
    parameter int NREG  = 16,
    parameter int TAG_W = 4,
    localparam int IDX_W = $clog2(NREG)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ren_en,
    input  logic [IDX_W-1:0] ren_idx,
    input  logic [TAG_W-1:0] ren_tag,
    input  logic             bus_valid,
    input  logic [TAG_W-1:0] bus_tag,
    output logic [TAG_W-1:0] qi_q    [NREG],
    output logic [NREG-1:0]  match
);
    import frs_pkg::*;

    logic bus_live;

    // Bus carries a usable tag this cycle
    always_comb bus_live = bus_valid && tag_live(16'(bus_tag));

    for (genvar i = 0; i < NREG; i++) begin : g_entry
        logic ren_here;

        // Decode whether this entry is being renamed or matched
        always_comb begin
            ren_here = ren_en && (ren_idx == IDX_W'(i));
            match[i] = bus_live && (qi_q[i] == bus_tag);
        end

        // Producer field update: reset, rename, then clear on match
        always_ff @(posedge clk) begin
            if (!rst_n)
                qi_q[i] <= '0;
            else if (ren_here)
                qi_q[i] <= ren_tag;
            else if (match[i])
                qi_q[i] <= '0;
        end
    end

endmodule

// File: rtl/frs_value_file.sv
// Module: frs_value_file
// Register storage. An entry takes bus data when its match bit is set.
// Assumes: the match vector already holds the latest-producer rule.
module frs_value_file #(
    parameter int               NREG     = 16,
    parameter int               DATA_W   = 64,
    parameter logic [DATA_W-1:0] INIT_VAL = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NREG-1:0]   match,
    input  logic [DATA_W-1:0] bus_data,
    output logic [DATA_W-1:0] val_q [NREG]
);

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        // Load the initial value on reset, else capture a matching result
        always_ff @(posedge clk) begin
            if (!rst_n)
                val_q[i] <= INIT_VAL + DATA_W'(i);
            else if (match[i])
                val_q[i] <= bus_data;
        end
    end

endmodule

// File: rtl/frs_src_lookup.sv
// Module: frs_src_lookup
// Resolves one source operand: stored value, bus bypass, or wait tag.
// Assumes: it sees the table state from before this cycle's rename.
module frs_src_lookup #(
    parameter int NREG   = 16,
    parameter int TAG_W  = 4,
    parameter int DATA_W = 64,
    localparam int IDX_W = $clog2(NREG)
) (
    input  logic [IDX_W-1:0]  idx,
    input  logic [TAG_W-1:0]  qi_q  [NREG],
    input  logic [DATA_W-1:0] val_q [NREG],
    input  logic              bus_valid,
    input  logic [TAG_W-1:0]  bus_tag,
    input  logic [DATA_W-1:0] bus_data,
    output logic [DATA_W-1:0] out_val,
    output logic [TAG_W-1:0]  out_tag
);
    import frs_pkg::*;

    logic [TAG_W-1:0]  prod;
    logic [DATA_W-1:0] stored;
    src_kind_e         kind;

    // Select the source kind from the producer and the bus
    always_comb begin
        prod   = qi_q[idx];
        stored = val_q[idx];
        if (!tag_live(16'(prod)))
            kind = SRC_FROM_FILE;
        else if (bus_valid && bus_tag == prod)
            kind = SRC_FROM_BUS;
        else
            kind = SRC_WAIT_TAG;
    end

    // Drive the operand fields for the chosen kind
    always_comb begin
        unique case (kind)
            SRC_FROM_FILE: begin out_val = stored;   out_tag = '0;   end
            SRC_FROM_BUS:  begin out_val = bus_data; out_tag = '0;   end
            default:       begin out_val = '0;       out_tag = prod; end
        endcase
    end

endmodule

// File: rtl/fp_rename_status.sv
// Module: fp_rename_status (top)
// Register file with one producer tag per register for a tag-renaming
// issue stage. It resolves two sources per issue, renames the destination,
// and accepts bus results only from each register's latest producer.
// Assumes: iss_tag is nonzero whenever iss_valid and iss_dst_en are high.
module fp_rename_status #(
    parameter int                NREG     = 16,
    parameter int                TAG_W    = 4,
    parameter int                DATA_W   = 64,
    parameter logic [DATA_W-1:0] INIT_VAL = '0,
    localparam int               IDX_W    = $clog2(NREG),
    localparam int               NSRC     = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              iss_valid,
    input  logic              iss_dst_en,
    input  logic [IDX_W-1:0]  iss_src_a_idx,
    input  logic [IDX_W-1:0]  iss_src_b_idx,
    input  logic [IDX_W-1:0]  iss_dst_idx,
    input  logic [TAG_W-1:0]  iss_tag,
    output logic [DATA_W-1:0] src_a_val,
    output logic [TAG_W-1:0]  src_a_tag,
    output logic [DATA_W-1:0] src_b_val,
    output logic [TAG_W-1:0]  src_b_tag,
    input  logic              bus_valid,
    input  logic [TAG_W-1:0]  bus_tag,
    input  logic [DATA_W-1:0] bus_data,
    input  logic [IDX_W-1:0]  dbg_idx,
    output logic [DATA_W-1:0] dbg_val,
    output logic [TAG_W-1:0]  dbg_tag
);

    logic [TAG_W-1:0]  qi_q  [NREG];
    logic [DATA_W-1:0] val_q [NREG];
    logic [NREG-1:0]   match;
    logic              ren_en;
    logic [IDX_W-1:0]  src_idx [NSRC];
    logic [DATA_W-1:0] src_val [NSRC];
    logic [TAG_W-1:0]  src_tag [NSRC];

    // Rename happens only for issued instructions that write a register
    always_comb ren_en = iss_valid && iss_dst_en;

    // Gather source indices into a port array
    always_comb begin
        src_idx[0] = iss_src_a_idx;
        src_idx[1] = iss_src_b_idx;
    end

    frs_tag_table #(.NREG(NREG), .TAG_W(TAG_W)) tags_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .ren_en    (ren_en),
        .ren_idx   (iss_dst_idx),
        .ren_tag   (iss_tag),
        .bus_valid (bus_valid),
        .bus_tag   (bus_tag),
        .qi_q      (qi_q),
        .match     (match)
    );

    frs_value_file #(.NREG(NREG), .DATA_W(DATA_W), .INIT_VAL(INIT_VAL)) vals_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .match    (match),
        .bus_data (bus_data),
        .val_q    (val_q)
    );

    for (genvar s = 0; s < NSRC; s++) begin : g_src
        frs_src_lookup #(.NREG(NREG), .TAG_W(TAG_W), .DATA_W(DATA_W)) look_i (
            .idx       (src_idx[s]),
            .qi_q      (qi_q),
            .val_q     (val_q),
            .bus_valid (bus_valid),
            .bus_tag   (bus_tag),
            .bus_data  (bus_data),
            .out_val   (src_val[s]),
            .out_tag   (src_tag[s])
        );
    end

    // Map resolved operands to the issue outputs
    always_comb begin
        src_a_val = src_val[0];
        src_a_tag = src_tag[0];
        src_b_val = src_val[1];
        src_b_tag = src_tag[1];
    end

    // Raw debug read of stored state, no bypass
    always_comb begin
        dbg_val = val_q[dbg_idx];
        dbg_tag = qi_q[dbg_idx];
    end

endmodule

// File: rtl/frs_checker.sv
// Module: frs_checker
// Temporal checks on the producer table, bound into fp_rename_status.
module frs_checker #(
    parameter int NREG   = 16,
    parameter int TAG_W  = 4,
    parameter int DATA_W = 64,
    localparam int IDX_W = $clog2(NREG)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              iss_valid,
    input logic              iss_dst_en,
    input logic [IDX_W-1:0]  iss_dst_idx,
    input logic [TAG_W-1:0]  iss_tag,
    input logic [DATA_W-1:0] src_a_val,
    input logic [TAG_W-1:0]  src_a_tag,
    input logic              bus_valid,
    input logic [TAG_W-1:0]  bus_tag,
    input logic [DATA_W-1:0] bus_data,
    input logic [TAG_W-1:0]  qi_q  [NREG],
    input logic [DATA_W-1:0] val_q [NREG]
);

    // R4: the destination records the issuing tag
    a_r4_rename_recorded: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && iss_dst_en) |=> qi_q[$past(iss_dst_idx)] == $past(iss_tag));

    // R3: a waiting source carries no value and no same-cycle bus match
    a_r3_wait_has_no_value: assert property (@(posedge clk) disable iff (!rst_n)
        (src_a_tag != '0) |-> (src_a_val == '0 && !(bus_valid && bus_tag == src_a_tag)));

    for (genvar k = 0; k < NREG; k++) begin : g_k
        // R1: producers are clear right after reset
        a_r1_reset_clear: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(rst_n) |-> qi_q[k] == '0);

        // R5: the latest producer's result is written and its field cleared
        a_r5_winner_writes: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_valid && bus_tag != '0 && qi_q[k] == bus_tag
             && !(iss_valid && iss_dst_en && iss_dst_idx == IDX_W'(k)))
            |=> (qi_q[k] == '0 && val_q[k] == $past(bus_data)));

        // R6: without a matching broadcast the value holds
        a_r6_stale_dropped: assert property (@(posedge clk) disable iff (!rst_n)
            !(bus_valid && bus_tag != '0 && qi_q[k] == bus_tag) |=> $stable(val_q[k]));
    end

endmodule

bind fp_rename_status frs_checker #(.NREG(NREG), .TAG_W(TAG_W), .DATA_W(DATA_W)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .iss_valid   (iss_valid),
    .iss_dst_en  (iss_dst_en),
    .iss_dst_idx (iss_dst_idx),
    .iss_tag     (iss_tag),
    .src_a_val   (src_a_val),
    .src_a_tag   (src_a_tag),
    .bus_valid   (bus_valid),
    .bus_tag     (bus_tag),
    .bus_data    (bus_data),
    .qi_q        (qi_q),
    .val_q       (val_q)
);

// File: tb/fp_rename_status_tb_top.sv
`timescale 1ns/100ps
// Bench: behavioural reference model of the producer table, compared
// every clock on both sources and one debug register, plus full sweeps.
module fp_rename_status_tb_top;
    localparam int          NREG  = 16;
    localparam int          TW    = 4;
    localparam int          DW    = 64;
    localparam int          IW    = 4;
    localparam logic [63:0] INITV = 64'h4000_0000_0000_1000;

    logic clk = 0, rst_n = 0;
    logic iss_valid = 0, iss_dst_en = 0;
    logic [IW-1:0] sa = 0, sb = 0, sd = 0, dbg_idx = 0;
    logic [TW-1:0] iss_tag = 0, bus_tag = 0;
    logic bus_valid = 0;
    logic [DW-1:0] bus_data = 0;
    logic [DW-1:0] sav, sbv, dbv;
    logic [TW-1:0] sat, sbt, dbt;

    int checks = 0, errors = 0, cyc = 0;
    bit done = 0;

    logic [DW-1:0] m_val [NREG];
    logic [TW-1:0] m_qi  [NREG];

    always #2.5 clk = ~clk;

    fp_rename_status #(.NREG(NREG), .TAG_W(TW), .DATA_W(DW), .INIT_VAL(INITV)) dut_i (
        .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_dst_en(iss_dst_en),
        .iss_src_a_idx(sa), .iss_src_b_idx(sb), .iss_dst_idx(sd), .iss_tag(iss_tag),
        .src_a_val(sav), .src_a_tag(sat), .src_b_val(sbv), .src_b_tag(sbt),
        .bus_valid(bus_valid), .bus_tag(bus_tag), .bus_data(bus_data),
        .dbg_idx(dbg_idx), .dbg_val(dbv), .dbg_tag(dbt));

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act=%h exp=%h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // Expected source resolution from the model
    task automatic exp_src(input int idx, output logic [63:0] v, output logic [3:0] t);
        if (m_qi[idx] == 0) begin v = m_val[idx]; t = 0; end
        else if (bus_valid && bus_tag == m_qi[idx]) begin v = bus_data; t = 0; end
        else begin v = 0; t = m_qi[idx]; end
    endtask

    task automatic model_reset();
        for (int i = 0; i < NREG; i++) begin m_val[i] = INITV + 64'(i); m_qi[i] = 0; end
    endtask

    // Model update at the clock edge, using inputs held through the edge
    task automatic model_edge();
        logic [NREG-1:0] hit;
        for (int i = 0; i < NREG; i++)
            hit[i] = bus_valid && bus_tag != 0 && m_qi[i] == bus_tag;
        for (int i = 0; i < NREG; i++)
            if (hit[i]) begin m_val[i] = bus_data; m_qi[i] = 0; end
        if (iss_valid && iss_dst_en) m_qi[sd] = iss_tag;
    endtask

    // One clock: inputs already set; compare, then advance
    task automatic step(input string req);
        logic [63:0] v; logic [3:0] t;
        dbg_idx = IW'(cyc % NREG);
        #0.5;
        if (iss_valid) begin
            exp_src(int'(sa), v, t);
            chk(sav == v && sat == t, req, {sat, sav[59:0]}, {t, v[59:0]});
            exp_src(int'(sb), v, t);
            chk(sbv == v && sbt == t, req, {sbt, sbv[59:0]}, {t, v[59:0]});
        end
        chk(dbv == m_val[dbg_idx] && dbt == m_qi[dbg_idx], "R11 debug", dbv, m_val[dbg_idx]);
        @(posedge clk);
        model_edge();
        cyc++;
        @(negedge clk);
        iss_valid = 0; iss_dst_en = 0; bus_valid = 0; bus_tag = 0;
    endtask

    // Full comparison of every register through the debug port
    task automatic sweep(input string req);
        for (int i = 0; i < NREG; i++) begin
            dbg_idx = IW'(i);
            #0.1;
            chk(dbv == m_val[i], req, dbv, m_val[i]);
            chk(dbt == m_qi[i], req, 64'(dbt), 64'(m_qi[i]));
        end
    endtask

    task automatic issue(input int a, input int b, input int d, input bit den, input int tg);
        iss_valid = 1; iss_dst_en = den; sa = IW'(a); sb = IW'(b); sd = IW'(d); iss_tag = TW'(tg);
    endtask

    task automatic bcast(input int tg, input logic [63:0] data);
        bus_valid = 1; bus_tag = TW'(tg); bus_data = data;
    endtask

    initial begin
        #150000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired act=%0d exp=done", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: reset state
        sweep("R1 reset state");

        // R2: sources with no producer read the file
        issue(3, 7, 0, 0, 0); step("R2 value from file");
        // R4: rename F6 to tag 5; R10: same instruction reads F6 before rename
        issue(6, 6, 6, 1, 5); step("R10 read before rename");
        // R3: a later reader waits on tag 5
        issue(6, 2, 8, 1, 9); step("R3 tag when pending");
        // R4: rename F6 again while tag 5 pending
        issue(1, 6, 6, 1, 11); step("R4 rename over pending");
        sweep("R4 producer overwritten");
        // R6: stale result from tag 5 is dropped
        bcast(5, 64'hDEAD_0000_0000_0005); step("R6 stale broadcast");
        sweep("R6 stale dropped");
        // R9: tag zero broadcast does nothing
        bcast(0, 64'h1234); step("R9 tag zero bus");
        sweep("R9 no change");
        // R7: bypass of tag 11 into a source, R5 write and clear
        issue(6, 8, 2, 1, 3); bcast(11, 64'hCAFE_0000_0000_0011); step("R7 bus bypass");
        sweep("R5 winner written");
        // R8: rename and matching broadcast on the same register
        issue(0, 1, 8, 1, 12); bcast(9, 64'hBEEF_0000_0000_0009); step("R8 rename over clear");
        sweep("R8 value and new tag");
        // R4: dst_en low leaves producers unchanged
        issue(4, 5, 4, 0, 7); step("R4 no dst");
        sweep("R4 no dst effect");

        // Random traffic against the model
        for (int n = 0; n < 3000; n++) begin
            if ($urandom_range(0, 3) != 0)
                issue($urandom_range(0, 15), $urandom_range(0, 15), $urandom_range(0, 15),
                      $urandom_range(0, 4) != 0, $urandom_range(1, 15));
            if ($urandom_range(0, 2) != 0)
                bcast($urandom_range(0, 15), {$urandom, $urandom});
            step("R5 R6 R7 random traffic");
            if (n % 500 == 499) sweep("R5 R6 random state");
        end

        // R1: reset again in mid-run
        rst_n = 0; step("R1 reset");
        model_reset();
        rst_n = 1;
        sweep("R1 second reset");

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule